// File: doc/BRIEF.md
# Power-to-Pulse Frequency Converter

This block turns a stream of per-phase power samples into a pulse train whose rate follows the total power. On every sample strobe it forms a total from the three signed phase inputs, using only the phases enabled in a 3-bit mask. The total is either the signed sum of those phases or the sum of their absolute values, chosen by a mode bit. The magnitude of the total, multiplied by a rate numerator, is added to an accumulator. Each time the accumulator reaches a threshold set by the rate denominator, the threshold is taken off and one output pulse is issued.

The pulse width is chosen when each pulse starts. It is a fixed nominal width when the denominator does not exceed the numerator, and it grows with the denominator when the denominator is larger. When the interval since the previous pulse start exceeds a long-period limit, a fixed capped width is used instead. Both limits are clock counts derived from the clock-frequency parameter. Threshold crossings that occur while a pulse is high are queued and issued afterwards, so no energy quantum is lost.

Top module: `pwr_pulse_conv`

## Requirements
- R1: Bit 0 of `phaseSel` enables phase A, bit 1 enables phase B and bit 2 enables phase C. A phase whose bit is clear contributes nothing to the total.
- R2: With `absMode` = 0 the total is the signed sum of the enabled phases, and the magnitude of that sum is what gets accumulated. Opposite phases of equal size therefore produce no pulses.
- R3: With `absMode` = 1 the total is the sum of the absolute values of the enabled phases.
- R4: On each strobe, |total| × `rateNum` is added to the accumulator. Each time the accumulator is at least effDen × 2^THRESH_SHIFT, that amount is subtracted and exactly one pulse is produced. Over a run, the pulse count equals floor(sum of the increments / threshold).
- R5: When effDen equals `rateNum`, each pulse is NOMINAL_W clocks wide (64 by default).
- R6: When effDen is greater than `rateNum`, each pulse is ceil(effDen/2) × DEN_UNIT clocks wide. This is half the denominator rounded to nearest, with halves rounded up.
- R7: When effDen is less than `rateNum`, each pulse is NOMINAL_W clocks wide.
- R8: The long-period rule overrides R5 to R7. If more than LONG_CLKS = CLK_HZ/1000 × 180 clocks have passed since the previous pulse start (or since reset), the new pulse is CAP_CLKS = CLK_HZ/1000 × 90 clocks wide.
- R9: No pulse starts while `pulseOut` is high. Crossings that occur meanwhile are queued (up to 2^PEND_W − 1) and issued later, each after exactly one low clock.
- R10: A `rateDen` of zero behaves as a denominator of one (effDen = 1) for both the threshold and the width choice.
- R11: Reset drives `pulseOut` low and empties both the accumulator and the queue. A pulse that is in progress or pending at reset is never emitted.
- R12: When a strobe at clock edge k makes the accumulator reach the threshold and no pulse is high, `pulseOut` rises at edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Phase samples are valid this cycle |
| phaseA | input | SAMPLE_W | Signed power sample, phase A |
| phaseB | input | SAMPLE_W | Signed power sample, phase B |
| phaseC | input | SAMPLE_W | Signed power sample, phase C |
| phaseSel | input | 3 | Phase enable mask (bit0 A, bit1 B, bit2 C) |
| absMode | input | 1 | 1: sum of absolute values, 0: signed sum |
| rateNum | input | RATIO_W | Rate scale numerator |
| rateDen | input | RATIO_W | Rate scale denominator (0 treated as 1) |
| pulseOut | output | 1 | Pulse output |

## Verification
Two functions can fall in the same cycle: a threshold crossing, and a pulse that is still high or is just ending. The crossing must then be queued rather than started or dropped. This is provoked with a single strobe worth three thresholds at a 1:1 ratio, which leaves two crossings waiting behind the first pulse. The result is judged by a pulse count of three, nominal widths on all three pulses, and exactly one low clock between consecutive pulses. A vector with more than one crossing per strobe interval repeats the same collision over a longer run, and its total pulse count must still equal the floor of the accumulated energy over the threshold.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // Strobes issued by the pulse control toward the accumulation datapath.
  typedef struct packed {
    logic take;   // a pulse starts this cycle and consumes one quantum
  } ppStrobes_t;
endpackage

// File: rtl/pp_datapath.sv
module pp_datapath
  import pp_pkg::*;
#(
  parameter int SAMPLE_W     = 16,
  parameter int RATIO_W      = 8,
  parameter int THRESH_SHIFT = 12,
  parameter int PEND_W       = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sampleValid,
  input  logic [3*SAMPLE_W-1:0]   phaseBus,
  input  logic [2:0]              phaseSel,
  input  logic                    absMode,
  input  logic [RATIO_W-1:0]      rateNum,
  input  logic [RATIO_W-1:0]      rateDen,
  input  ppStrobes_t              ctl,
  output logic                    pendingAny
);
  localparam int SUM_W  = SAMPLE_W + 2;
  localparam int INC_W  = SUM_W + RATIO_W;
  localparam int THR_W  = RATIO_W + THRESH_SHIFT;
  localparam int ACC_W  = ((INC_W > THR_W) ? INC_W : THR_W) + 1;
  localparam int ACCX_W = ACC_W + 1;

  logic signed [SUM_W-1:0] term [3];
  logic signed [SUM_W-1:0] total;
  logic [SUM_W-1:0]        totalMag;
  logic [INC_W-1:0]        inc;
  logic [RATIO_W-1:0]      effDen;
  logic [ACC_W-1:0]        threshWide;
  logic [ACC_W-1:0]        acc;
  logic [ACC_W-1:0]        accNext;
  logic [ACCX_W-1:0]       accSum;
  logic [PEND_W-1:0]       pendCnt;
  logic                    crossNow;

  // Per-phase selection and optional magnitude (R1, R3)
  for (genvar gi = 0; gi < 3; gi++) begin : g_phase
    logic signed [SAMPLE_W-1:0] raw;
    logic signed [SUM_W-1:0]    ext;
    assign raw = phaseBus[gi*SAMPLE_W +: SAMPLE_W];
    assign ext = {{2{raw[SAMPLE_W-1]}}, raw};
    assign term[gi] = !phaseSel[gi] ? '0 :
                      (absMode && ext[SUM_W-1]) ? -ext : ext;
  end

  // Signed total and its magnitude (R2)
  assign total    = term[0] + term[1] + term[2];
  assign totalMag = total[SUM_W-1] ? $unsigned(-total) : $unsigned(total);
  assign inc      = INC_W'(totalMag) * INC_W'(rateNum);

  // Threshold from the denominator, zero read as one (R10)
  assign effDen     = (rateDen == '0) ? RATIO_W'(1) : rateDen;
  assign threshWide = ACC_W'(effDen) << THRESH_SHIFT;
  assign crossNow   = (acc >= threshWide);

  assign accSum  = {1'b0, acc}
                 + (sampleValid ? ACCX_W'(inc) : '0)
                 - (crossNow ? {1'b0, threshWide} : '0);
  assign accNext = accSum[ACC_W] ? '1 : accSum[ACC_W-1:0];

  assign pendingAny = (pendCnt != '0) || crossNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      pendCnt <= '0;
    end else begin
      acc <= accNext;
      case ({crossNow, ctl.take})
        2'b10: if (pendCnt != '1) pendCnt <= pendCnt + PEND_W'(1);
        2'b01: pendCnt <= pendCnt - PEND_W'(1);
        default: ;
      endcase
    end
  end

  // A pulse may only start when a quantum is waiting (R9)
  p_take_backed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.take |-> (pendCnt != '0 || crossNow));

  // Without a sample the accumulator never grows (R4)
  p_no_gain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> acc <= $past(acc));

endmodule

// File: rtl/pp_width.sv
module pp_width #(
  parameter int RATIO_W   = 8,
  parameter int TIME_W    = 16,
  parameter int NOMINAL_W = 64,
  parameter int DEN_UNIT  = 64,
  parameter int LONG_CLKS = 1000,
  parameter int CAP_CLKS  = 500
) (
  input  logic [RATIO_W-1:0] rateNum,
  input  logic [RATIO_W-1:0] rateDen,
  input  logic [TIME_W-1:0]  periodCnt,
  output logic [TIME_W-1:0]  widthSel
);
  logic [RATIO_W-1:0] effDen;
  logic [RATIO_W-1:0] halfUp;

  assign effDen = (rateDen == '0) ? RATIO_W'(1) : rateDen;
  assign halfUp = (effDen >> 1) + RATIO_W'(effDen[0]);

  // Long period wins (R8), then denominator scaling (R6), else nominal (R5, R7)
  always_comb begin
    if (periodCnt > TIME_W'(LONG_CLKS))
      widthSel = TIME_W'(CAP_CLKS);
    else if (effDen > rateNum)
      widthSel = TIME_W'(halfUp) * TIME_W'(DEN_UNIT);
    else
      widthSel = TIME_W'(NOMINAL_W);
  end
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
#(
  parameter int TIME_W    = 16,
  parameter int LONG_CLKS = 1000,
  parameter int CAP_CLKS  = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pendingAny,
  input  logic [TIME_W-1:0] widthSel,
  output ppStrobes_t        ctl,
  output logic [TIME_W-1:0] periodCnt,
  output logic              pulseOut
);
  logic [TIME_W-1:0] hiCnt;
  logic              pulseReg;

  // Start only from low (R9)
  always_comb ctl.take = !pulseReg && pendingAny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulseReg  <= 1'b0;
      hiCnt     <= '0;
      periodCnt <= '0;
    end else if (ctl.take) begin
      pulseReg  <= 1'b1;
      hiCnt     <= widthSel - TIME_W'(1);
      periodCnt <= TIME_W'(1);
    end else begin
      if (pulseReg) begin
        if (hiCnt == '0) pulseReg <= 1'b0;
        else             hiCnt    <= hiCnt - TIME_W'(1);
      end
      if (periodCnt <= TIME_W'(LONG_CLKS))
        periodCnt <= periodCnt + TIME_W'(1);
    end
  end

  assign pulseOut = pulseReg;

  p_width_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.take |-> widthSel != '0);

  p_cap_used_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.take && periodCnt > TIME_W'(LONG_CLKS)) |-> widthSel == TIME_W'(CAP_CLKS));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulseReg && hiCnt != '0) |=> pulseReg);

  p_period_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    periodCnt <= TIME_W'(LONG_CLKS + 1));

endmodule

// File: rtl/pwr_pulse_conv.sv
module pwr_pulse_conv
  import pp_pkg::*;
#(
  parameter int SAMPLE_W     = 16,
  parameter int RATIO_W      = 8,
  parameter int CLK_HZ       = 100_000_000,
  parameter int THRESH_SHIFT = 12,
  parameter int NOMINAL_W    = 64,
  parameter int DEN_UNIT     = 64,
  parameter int PEND_W       = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] phaseA,
  input  logic signed [SAMPLE_W-1:0] phaseB,
  input  logic signed [SAMPLE_W-1:0] phaseC,
  input  logic [2:0]                 phaseSel,
  input  logic                       absMode,
  input  logic [RATIO_W-1:0]         rateNum,
  input  logic [RATIO_W-1:0]         rateDen,
  output logic                       pulseOut
);
  localparam int MS_CLKS   = CLK_HZ / 1000;
  localparam int LONG_CLKS = MS_CLKS * 180;
  localparam int CAP_CLKS  = MS_CLKS * 90;
  localparam int DEN_MAX   = (2 ** (RATIO_W - 1)) * DEN_UNIT;
  localparam int T1        = (LONG_CLKS + 1 > DEN_MAX) ? LONG_CLKS + 1 : DEN_MAX;
  localparam int T2        = (T1 > NOMINAL_W) ? T1 : NOMINAL_W;
  localparam int TIME_W    = $clog2(T2 + 1) + 1;

  logic [3*SAMPLE_W-1:0] phaseBus;
  ppStrobes_t            ctl;
  logic                  pendingAny;
  logic [TIME_W-1:0]     periodCnt;
  logic [TIME_W-1:0]     widthSel;

  assign phaseBus = {phaseC, phaseB, phaseA};

  pp_datapath #(
    .SAMPLE_W(SAMPLE_W), .RATIO_W(RATIO_W),
    .THRESH_SHIFT(THRESH_SHIFT), .PEND_W(PEND_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid),
    .phaseBus(phaseBus), .phaseSel(phaseSel), .absMode(absMode),
    .rateNum(rateNum), .rateDen(rateDen), .ctl(ctl),
    .pendingAny(pendingAny)
  );

  pp_width #(
    .RATIO_W(RATIO_W), .TIME_W(TIME_W), .NOMINAL_W(NOMINAL_W),
    .DEN_UNIT(DEN_UNIT), .LONG_CLKS(LONG_CLKS), .CAP_CLKS(CAP_CLKS)
  ) u_width (
    .rateNum(rateNum), .rateDen(rateDen),
    .periodCnt(periodCnt), .widthSel(widthSel)
  );

  pp_ctrl #(
    .TIME_W(TIME_W), .LONG_CLKS(LONG_CLKS), .CAP_CLKS(CAP_CLKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pendingAny(pendingAny),
    .widthSel(widthSel), .ctl(ctl), .periodCnt(periodCnt),
    .pulseOut(pulseOut)
  );
endmodule

// File: tb/pwr_pulse_conv_tb.sv
module pwr_pulse_conv_tb;
  // Bench parameters: 100 clocks per ms, so the long period is 18000 clocks
  // and the capped width 9000; threshold = effDen*16; width unit 4 clocks.
  localparam int CLK_HZ = 100_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] phaseA = '0, phaseB = '0, phaseC = '0;
  logic [2:0] phaseSel = '0;
  logic absMode = 1'b0;
  logic [7:0] rateNum = '0, rateDen = '0;
  logic pulseOut;

  always #5 clk = ~clk;

  pwr_pulse_conv #(
    .SAMPLE_W(16), .RATIO_W(8), .CLK_HZ(CLK_HZ), .THRESH_SHIFT(4),
    .NOMINAL_W(64), .DEN_UNIT(4), .PEND_W(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid),
    .phaseA(phaseA), .phaseB(phaseB), .phaseC(phaseC),
    .phaseSel(phaseSel), .absMode(absMode),
    .rateNum(rateNum), .rateDen(rateDen), .pulseOut(pulseOut)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic        absm;
    logic [15:0] a, b, c;
    logic [7:0]  num, den;
    logic [15:0] expPulses;
    logic [15:0] expWidth;   // 0: width not checked
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{3'b111, 1'b0,  16'sd10,  16'sd20, -16'sd6, 8'd2, 8'd3, 16'd10, 16'd8 },  // R1 R2 R6: 24*2 vs 48
    '{3'b011, 1'b0,  16'sd10,  16'sd20, -16'sd6, 8'd1, 8'd1, 16'd18, 16'd64},  // R1 R5 R9: backlog
    '{3'b100, 1'b0,  16'sd10,  16'sd20, -16'sd6, 8'd4, 8'd4, 16'd3,  16'd64},  // R1 R2: negative phase only
    '{3'b011, 1'b0,  16'sd50, -16'sd50,  16'sd9, 8'd1, 8'd8, 16'd0,  16'd0 },  // R2: cancellation
    '{3'b011, 1'b1,  16'sd50, -16'sd50,  16'sd9, 8'd1, 8'd8, 16'd7,  16'd16},  // R3 R6
    '{3'b001, 1'b0,  16'sd16,  16'sd0,   16'sd0, 8'd1, 8'd0, 16'd10, 16'd64},  // R10
    '{3'b001, 1'b0,  16'sd8,   16'sd0,   16'sd0, 8'd5, 8'd2, 16'd12, 16'd64},  // R7
    '{3'b111, 1'b0, -16'sd10, -16'sd20, -16'sd6, 8'd1, 8'd5, 16'd4,  16'd12},  // R2 R6: odd rounding
    '{3'b101, 1'b1, -16'sd10,  16'sd99,  16'sd7, 8'd3, 8'd3, 16'd10, 16'd64}   // R1 R3: B excluded
  };

  int nChecks = 0;
  int nFail = 0;

  // Output monitor, sampling away from the active edge
  int expW = 0;
  int pulseCnt, doneCnt, curW, curGap, badW, firstBad;
  int wLog [4];
  int gLog [4];
  logic prevP;

  always @(negedge clk) begin
    if (!rst_n) begin
      pulseCnt <= 0; doneCnt <= 0; curW <= 0; curGap <= 0;
      badW <= 0; firstBad <= 0; prevP <= 1'b0;
      for (int i = 0; i < 4; i++) begin wLog[i] <= 0; gLog[i] <= 0; end
    end else begin
      prevP <= pulseOut;
      if (pulseOut) begin
        if (!prevP) begin
          if (pulseCnt < 4) gLog[pulseCnt] <= curGap;
          pulseCnt <= pulseCnt + 1;
          curW <= 1;
        end else curW <= curW + 1;
      end else if (prevP) begin
        if (doneCnt < 4) wLog[doneCnt] <= curW;
        doneCnt <= doneCnt + 1;
        if (expW != 0 && curW != expW) begin
          if (badW == 0) firstBad <= curW;
          badW <= badW + 1;
        end
        curGap <= 1;
      end else curGap <= curGap + 1;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sendSamples(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sampleValid = 1'b1;
      @(negedge clk) sampleValid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic setCfg(input logic [2:0] s, input logic am, input logic signed [15:0] a,
                        input logic signed [15:0] b, input logic signed [15:0] c,
                        input logic [7:0] nu, input logic [7:0] de);
    phaseSel = s; absMode = am; phaseA = a; phaseB = b; phaseC = c;
    rateNum = nu; rateDen = de;
  endtask

  initial begin
    // R11: output low out of reset with a live configuration
    setCfg(3'b001, 1'b0, 16'sd48, 16'sd0, 16'sd0, 8'd1, 8'd1);
    doReset();
    @(negedge clk);
    check(pulseOut == 1'b0, "R11 pulseOut after reset", int'(pulseOut), 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      setCfg(VECS[v].sel, VECS[v].absm, VECS[v].a, VECS[v].b, VECS[v].c,
             VECS[v].num, VECS[v].den);
      expW = int'(VECS[v].expWidth);
      doReset();
      sendSamples(10, 100);
      repeat (3000) @(negedge clk);
      check(pulseCnt == int'(VECS[v].expPulses),
            $sformatf("R4 vec%0d pulse count", v), pulseCnt, int'(VECS[v].expPulses));
      if (expW != 0)
        check(badW == 0, $sformatf("R5/R6/R7/R10 vec%0d width", v), firstBad, expW);
    end

    // R12 and R9: one strobe worth three thresholds at ratio 1:1
    setCfg(3'b001, 1'b0, 16'sd48, 16'sd0, 16'sd0, 8'd1, 8'd1);
    expW = 64;
    doReset();
    @(negedge clk) sampleValid = 1'b1;
    @(negedge clk) sampleValid = 1'b0;
    check(pulseOut == 1'b0, "R12 low after accumulate edge", int'(pulseOut), 0);
    @(negedge clk);
    check(pulseOut == 1'b1, "R12 high one edge later", int'(pulseOut), 1);
    repeat (400) @(negedge clk);
    check(pulseCnt == 3, "R9 deferred pulses issued", pulseCnt, 3);
    check(badW == 0, "R9 deferred pulse width", firstBad, 64);
    check(gLog[1] == 1, "R9 gap before second pulse", gLog[1], 1);
    check(gLog[2] == 1, "R9 gap before third pulse", gLog[2], 1);

    // R11: reset while pulses are queued discards them
    doReset();
    @(negedge clk) sampleValid = 1'b1;
    @(negedge clk) sampleValid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(pulseOut == 1'b0, "R11 pulse cut by reset", int'(pulseOut), 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    check(pulseCnt == 0, "R11 queue emptied by reset", pulseCnt, 0);

    // R8: long period gives capped width, the following short period does not
    setCfg(3'b001, 1'b0, 16'sd16, 16'sd0, 16'sd0, 8'd1, 8'd1);
    expW = 0;
    doReset();
    repeat (20000) @(negedge clk);
    sendSamples(1, 9100);
    sendSamples(1, 300);
    check(pulseCnt == 2, "R8 pulse count", pulseCnt, 2);
    check(wLog[0] == 9000, "R8 capped width after long period", wLog[0], 9000);
    check(wLog[1] == 64, "R5 nominal width after short period", wLog[1], 64);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog R4 actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule